// File: doc/BRIEF.md
# PCIe TLP Trace Capture Filter

This block sits beside a PCIe core and looks at every transaction-layer packet header the core reports. For each header it decides whether the header should go to the trace store. It passes the accepted header onward with a one-cycle capture strobe. The decision combines three tests:

- **Source selection:** either a set of root ports or one exact requester ID.
- **Packet class:** posted, non-posted or completion.
- **Direction:** the meaning of the direction code depends on the chosen record format, and inbound completions are split into two subclasses.

Software writes a filter word, a type mask, a direction code and a format code, then pulses a load strobe. The block checks the new settings when they are loaded. A combination the trace hardware cannot honour raises an error flag. That flag stays set, and no capture happens, until a later load brings legal settings. Header storage, memory writes and link-level decoding are handled by neighbouring logic.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset `cap_valid` and `cfg_error` are 0, and no header is captured until a legal configuration has been loaded with `cfg_load`.
- R2: A pulse of `cfg_load` registers `cfg_filter`, `cfg_type`, `cfg_dir` and `cfg_fmt` at that clock edge. If the settings are legal, `cfg_error` reads 0 and capture is enabled for headers presented from the next cycle on.
- R3: When `cfg_filter` bit 19 is 1 (root-port mode), bits 15:0 form a port mask and a header passes when the bit indexed by `hdr_port` is set. Several bits may be set at once, and bits 18:16 are ignored.
- R4: When `cfg_filter` bit 19 is 0 (requester mode), a header passes only when `hdr_rid` equals `cfg_filter[15:0]` exactly.
- R5: `hdr_kind` is 0 for posted, 1 for non-posted, 2 for completion and 3 for reserved. A header passes only when `cfg_type` bit `hdr_kind` is set: bit 0 selects posted, bit 1 non-posted and bit 2 completion. Kind 3 never passes, and `cfg_type` bits 7:3 are ignored.
- R6: With `cfg_fmt`=0 (four-word records), the direction codes select the following traffic. Completions with `hdr_cpl_b`=1 are class B and all other completions are class A.
  - 0: all inbound headers.
  - 1: all outbound headers.
  - 2: all outbound headers, plus inbound posted, non-posted and class-B completions.
  - 3: all outbound headers, plus inbound class-A completions.
- R7: With `cfg_fmt`=1 (eight-word records), the direction codes select the following traffic.
  - 1: all outbound headers.
  - 2: inbound posted, non-posted and class-B completions.
  - 3: inbound class-A completions only.
- R8: A load is illegal in any of these cases. An illegal load sets `cfg_error` to 1, and the flag holds with no capture until the next legal load.
  - `cfg_fmt` is greater than 1.
  - `cfg_dir` is greater than 3.
  - `cfg_dir` is 0 with `cfg_fmt`=1.
  - `cfg_type[2:0]` is 0.
  - More than one of `cfg_type[2:0]` is set while the direction code includes outbound traffic (format 0 codes 1 to 3, format 1 code 1).
- R9: A header presented with `hdr_valid` at clock edge k and accepted gives `cap_valid`=1 with `cap_data` equal to that `hdr_data` after edge k. `cap_data` keeps its last captured value whenever `cap_valid` is 0.
- R10: Without `hdr_valid` no capture happens, whatever the other header inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Load strobe for the four configuration words |
| cfg_filter | input | 20 | Mode bit 19, source selection in bits 15:0 |
| cfg_type | input | 8 | Packet class mask |
| cfg_dir | input | 4 | Direction code |
| cfg_fmt | input | 4 | Record format code (0 four-word, 1 eight-word) |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_data | input | 128 | Header words |
| hdr_outbound | input | 1 | 1 outbound, 0 inbound |
| hdr_port | input | 4 | Root-port index the packet uses |
| hdr_rid | input | 16 | Requester ID |
| hdr_kind | input | 2 | Packet class code |
| hdr_cpl_b | input | 1 | Completion subclass B flag |
| cap_valid | output | 1 | Capture strobe |
| cap_data | output | 128 | Accepted header |
| cfg_error | output | 1 | Sticky illegal-configuration flag |

## Verification
A table drives single headers against freshly loaded settings:

- Root-port masks with one bit and with several bits, including masks with the reserved bits set.
- Exact and off-by-one requester IDs.
- Every packet class against one-bit and multi-bit type masks.
- Each direction code in both formats, tried with outbound traffic, inbound class-A completions and inbound class-B completions.

Together these separate a wrong port index, a loose ID compare, a swapped subclass and a format-blind direction decode. Each illegal case is loaded in turn, and the bench checks that the error flag rises and capture stops. Directed sequences then cover the following:

- Capture before any load.
- Back-to-back headers, to check the one-cycle latency and the pass-through data.
- Data held over a rejected header.
- Inactive strobes.
- Recovery from an error by a legal reload.

// File: rtl/tlp_trace_pkg.sv
// Shared constants and types for the TLP trace capture filter.
// Assumes the filter word layout: mode in the top bit, value in the low 16.
package tlp_trace_pkg;

    localparam int FILT_W        = 20;
    localparam int FILT_MODE_BIT = 19;
    localparam int SEL_W         = 16;
    localparam int TYPE_W        = 8;
    localparam int KIND_BITS     = 3;
    localparam int DIR_W         = 4;
    localparam int FMT_W         = 4;

    // Packet class codes presented on hdr_kind
    typedef enum logic [1:0] {
        KIND_POSTED    = 2'd0,
        KIND_NONPOSTED = 2'd1,
        KIND_COMPL     = 2'd2,
        KIND_RSVD      = 2'd3
    } tlp_kind_e;

    // Direction code values (meaning depends on record format)
    localparam logic [DIR_W-1:0] DCODE_0 = 4'd0;
    localparam logic [DIR_W-1:0] DCODE_1 = 4'd1;
    localparam logic [DIR_W-1:0] DCODE_2 = 4'd2;
    localparam logic [DIR_W-1:0] DCODE_3 = 4'd3;

    // Record format codes
    localparam logic [FMT_W-1:0] FMT_NARROW = 4'd0;
    localparam logic [FMT_W-1:0] FMT_WIDE   = 4'd1;

    // Registered trace settings after a load
    typedef struct packed {
        logic                 port_mode;
        logic [SEL_W-1:0]     sel;
        logic [KIND_BITS-1:0] kinds;
        logic [1:0]           dcode;
        logic                 wide;
    } trace_cfg_t;

endpackage

// File: rtl/trace_cfg_reg.sv
// Configuration register and legality checker for the trace filter.
// Captures the settings on cfg_load, judges them once at that edge and
// holds the verdict (armed / cfg_error) until the next load.
// Assumes cfg_load is a single-cycle strobe from the control side.
module trace_cfg_reg
    import tlp_trace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [TYPE_W-1:0] cfg_type,
    input  logic [DIR_W-1:0]  cfg_dir,
    input  logic [FMT_W-1:0]  cfg_fmt,
    output trace_cfg_t        cfg_q,
    output logic              armed,
    output logic              cfg_error
);

    logic [KIND_BITS-1:0] new_kinds;
    logic                 fmt_ok;
    logic                 is_wide;
    logic                 dir_ok;
    logic                 has_outbound;
    logic                 kinds_none;
    logic                 kinds_multi;
    logic                 legal;
    logic                 unused_cfg_bits;

    assign new_kinds       = cfg_type[KIND_BITS-1:0];
    assign unused_cfg_bits = ^{cfg_filter[FILT_MODE_BIT-1:SEL_W], cfg_type[TYPE_W-1:KIND_BITS]};

    // Judge the incoming settings against the format-dependent rules
    always_comb begin
        fmt_ok       = (cfg_fmt == FMT_NARROW) || (cfg_fmt == FMT_WIDE);
        is_wide      = (cfg_fmt == FMT_WIDE);
        dir_ok       = (cfg_dir <= DCODE_3) && !(is_wide && (cfg_dir == DCODE_0));
        has_outbound = is_wide ? (cfg_dir == DCODE_1) : (cfg_dir != DCODE_0);
        kinds_none   = (new_kinds == '0);
        kinds_multi  = ((new_kinds & (new_kinds - 1'b1)) != '0);
        legal        = fmt_ok && dir_ok && !kinds_none && !(has_outbound && kinds_multi);
    end

    // Register the settings and the verdict on each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            armed     <= 1'b0;
            cfg_error <= 1'b0;
        end else if (cfg_load) begin
            cfg_q.port_mode <= cfg_filter[FILT_MODE_BIT];
            cfg_q.sel       <= cfg_filter[SEL_W-1:0];
            cfg_q.kinds     <= new_kinds;
            cfg_q.dcode     <= cfg_dir[1:0];
            cfg_q.wide      <= is_wide;
            armed           <= legal;
            cfg_error       <= !legal;
        end
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(cfg_error) && $stable(armed)));

    // R2
    load_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (armed != cfg_error));

endmodule

// File: rtl/trace_src_match.sv
// Source selection: root-port mask or exact requester ID.
// Assumes NUM_PORTS <= 16; ports beyond NUM_PORTS never match.
module trace_src_match
    import tlp_trace_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 4
) (
    input  logic              port_mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PORT_W-1:0] port,
    input  logic [SEL_W-1:0]  rid,
    output logic              src_hit
);

    localparam int PAD_N = 1 << PORT_W;

    logic [PAD_N-1:0] port_mask;

    // Build a mask covering every encodable port index
    for (genvar gi = 0; gi < PAD_N; gi++) begin : g_mask
        if (gi < NUM_PORTS && gi < SEL_W) begin : g_live
            assign port_mask[gi] = sel[gi];
        end else begin : g_dead
            assign port_mask[gi] = 1'b0;
        end
    end

    // Pick the test the current mode asks for
    always_comb begin
        if (port_mode) src_hit = port_mask[port];
        else           src_hit = (rid == sel);
    end

endmodule

// File: rtl/trace_dir_match.sv
// Packet class and direction match for the trace filter.
// Direction code meaning depends on the record format; inbound completions
// are split into class A and class B by cpl_b. cpl_b is ignored otherwise.
module trace_dir_match
    import tlp_trace_pkg::*;
(
    input  logic                 wide,
    input  logic [1:0]           dcode,
    input  logic [KIND_BITS-1:0] kinds,
    input  logic                 outbound,
    input  logic [1:0]           kind,
    input  logic                 cpl_b,
    output logic                 cls_hit,
    output logic                 dir_hit
);

    logic is_cpl;
    logic in_req_or_b;
    logic in_cpl_a;

    // Class test: the mask bit indexed by the packet class
    always_comb begin
        case (kind)
            KIND_POSTED:    cls_hit = kinds[0];
            KIND_NONPOSTED: cls_hit = kinds[1];
            KIND_COMPL:     cls_hit = kinds[2];
            default:        cls_hit = 1'b0;
        endcase
    end

    // Inbound traffic groups used by the mixed and wide codes
    always_comb begin
        is_cpl      = (kind == KIND_COMPL);
        in_req_or_b = !outbound && (!is_cpl || cpl_b);
        in_cpl_a    = !outbound && is_cpl && !cpl_b;
    end

    // Direction test for the active format
    always_comb begin
        case ({wide, dcode})
            3'b000:  dir_hit = !outbound;
            3'b001:  dir_hit = outbound;
            3'b010:  dir_hit = outbound || in_req_or_b;
            3'b011:  dir_hit = outbound || in_cpl_a;
            3'b100:  dir_hit = 1'b0;
            3'b101:  dir_hit = outbound;
            3'b110:  dir_hit = in_req_or_b;
            default: dir_hit = in_cpl_a;
        endcase
    end

endmodule

// File: rtl/tlp_trace_filter.sv
// TLP trace capture filter top. Combines source, class and direction tests
// against the loaded settings and registers the capture decision together
// with the header, one cycle after hdr_valid.
// Assumes one header per cycle at most and no back-pressure downstream.
module tlp_trace_filter
    import tlp_trace_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int HDR_W     = 128,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [TYPE_W-1:0] cfg_type,
    input  logic [DIR_W-1:0]  cfg_dir,
    input  logic [FMT_W-1:0]  cfg_fmt,
    input  logic              hdr_valid,
    input  logic [HDR_W-1:0]  hdr_data,
    input  logic              hdr_outbound,
    input  logic [PORT_W-1:0] hdr_port,
    input  logic [SEL_W-1:0]  hdr_rid,
    input  logic [1:0]        hdr_kind,
    input  logic              hdr_cpl_b,
    output logic              cap_valid,
    output logic [HDR_W-1:0]  cap_data,
    output logic              cfg_error
);

    trace_cfg_t cfg_q;
    logic       armed;
    logic       src_hit;
    logic       cls_hit;
    logic       dir_hit;
    logic       accept;

    trace_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_filter (cfg_filter),
        .cfg_type   (cfg_type),
        .cfg_dir    (cfg_dir),
        .cfg_fmt    (cfg_fmt),
        .cfg_q      (cfg_q),
        .armed      (armed),
        .cfg_error  (cfg_error)
    );

    trace_src_match #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_src (
        .port_mode (cfg_q.port_mode),
        .sel       (cfg_q.sel),
        .port      (hdr_port),
        .rid       (hdr_rid),
        .src_hit   (src_hit)
    );

    trace_dir_match u_dir (
        .wide     (cfg_q.wide),
        .dcode    (cfg_q.dcode),
        .kinds    (cfg_q.kinds),
        .outbound (hdr_outbound),
        .kind     (hdr_kind),
        .cpl_b    (hdr_cpl_b),
        .cls_hit  (cls_hit),
        .dir_hit  (dir_hit)
    );

    // Combine the individual tests with the arm state
    assign accept = hdr_valid && armed && src_hit && cls_hit && dir_hit;

    // Register the decision and hold the last accepted header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= accept;
            if (accept) cap_data <= hdr_data;
        end
    end

    // R8
    no_cap_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> !cap_valid);

    // R1
    no_cap_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !cap_valid);

    // R10
    idle_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !cap_valid);

    // R9
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_data == $past(hdr_data)));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> $stable(cap_data));

endmodule

// File: tb/tlp_trace_filter_bench.sv
`timescale 1ns/1ps
module tlp_trace_filter_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_load = 1'b0;
    logic [19:0]  cfg_filter = '0;
    logic [7:0]   cfg_type = '0;
    logic [3:0]   cfg_dir = '0;
    logic [3:0]   cfg_fmt = '0;
    logic         hdr_valid = 1'b0;
    logic [127:0] hdr_data = '0;
    logic         hdr_outbound = 1'b0;
    logic [3:0]   hdr_port = '0;
    logic [15:0]  hdr_rid = '0;
    logic [1:0]   hdr_kind = '0;
    logic         hdr_cpl_b = 1'b0;
    logic         cap_valid;
    logic [127:0] cap_data;
    logic         cfg_error;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tlp_trace_filter u_tlp_trace_filter (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_filter(cfg_filter),
        .cfg_type(cfg_type), .cfg_dir(cfg_dir), .cfg_fmt(cfg_fmt),
        .hdr_valid(hdr_valid), .hdr_data(hdr_data), .hdr_outbound(hdr_outbound),
        .hdr_port(hdr_port), .hdr_rid(hdr_rid), .hdr_kind(hdr_kind),
        .hdr_cpl_b(hdr_cpl_b), .cap_valid(cap_valid), .cap_data(cap_data),
        .cfg_error(cfg_error)
    );

    typedef struct packed {
        logic [19:0] filt;
        logic [2:0]  typ;
        logic [3:0]  dir;
        logic [3:0]  fmt;
        logic        ob;
        logic [3:0]  port;
        logic [15:0] rid;
        logic [1:0]  kind;
        logic        cplb;
        logic        exp_cap;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    // fields: filter, type, dir, fmt, outbound, port, rid, kind, cplb, exp cap, exp err, req
    localparam vec_t VECS [NV] = '{
        '{20'h80001, 3'b001, 4'd0, 4'd0, 1'b0, 4'd0,  16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 single port hit
        '{20'h80001, 3'b001, 4'd0, 4'd0, 1'b0, 4'd1,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 other port
        '{20'h88005, 3'b001, 4'd0, 4'd0, 1'b0, 4'd15, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 multi mask, top
        '{20'h88005, 3'b001, 4'd0, 4'd0, 1'b0, 4'd3,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 multi mask miss
        '{20'hF0004, 3'b001, 4'd0, 4'd0, 1'b0, 4'd2,  16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 reserved bits set
        '{20'h00101, 3'b001, 4'd0, 4'd0, 1'b0, 4'd0,  16'h0101, 2'd0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 exact
        '{20'h00101, 3'b001, 4'd0, 4'd0, 1'b0, 4'd0,  16'h0100, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 near miss
        '{20'h00101, 3'b010, 4'd0, 4'd0, 1'b0, 4'd0,  16'h0101, 2'd0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 wrong class
        '{20'h8FFFF, 3'b011, 4'd0, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd1, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 multi inbound
        '{20'h8FFFF, 3'b100, 4'd0, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 reserved kind
        '{20'h8FFFF, 3'b100, 4'd1, 4'd0, 1'b1, 4'd5,  16'h0000, 2'd2, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 code1 out
        '{20'h8FFFF, 3'b100, 4'd1, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 code1 in
        '{20'h8FFFF, 3'b001, 4'd0, 4'd0, 1'b1, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 code0 out
        '{20'h8FFFF, 3'b100, 4'd2, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b1, 1'b1, 1'b0, 4'd6}, // R6 code2 in B
        '{20'h8FFFF, 3'b100, 4'd2, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 code2 in A
        '{20'h8FFFF, 3'b100, 4'd3, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 code3 in A
        '{20'h8FFFF, 3'b100, 4'd3, 4'd0, 1'b1, 4'd5,  16'h0000, 2'd2, 1'b1, 1'b1, 1'b0, 4'd6}, // R6 code3 out
        '{20'h8FFFF, 3'b100, 4'd1, 4'd1, 1'b1, 4'd5,  16'h0000, 2'd2, 1'b0, 1'b1, 1'b0, 4'd7}, // R7 code1 out
        '{20'h8FFFF, 3'b100, 4'd2, 4'd1, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b1, 1'b1, 1'b0, 4'd7}, // R7 code2 in B
        '{20'h8FFFF, 3'b100, 4'd2, 4'd1, 1'b1, 4'd5,  16'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 code2 out
        '{20'h8FFFF, 3'b100, 4'd3, 4'd1, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b0, 1'b1, 1'b0, 4'd7}, // R7 code3 in A
        '{20'h8FFFF, 3'b100, 4'd3, 4'd1, 1'b0, 4'd5,  16'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 code3 in B
        '{20'h8FFFF, 3'b111, 4'd2, 4'd1, 1'b0, 4'd5,  16'h0000, 2'd1, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 legal multi inbound
        '{20'h8FFFF, 3'b001, 4'd0, 4'd1, 1'b0, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 wide code0
        '{20'h8FFFF, 3'b011, 4'd1, 4'd0, 1'b1, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 multi outbound
        '{20'h8FFFF, 3'b000, 4'd0, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 empty type
        '{20'h8FFFF, 3'b001, 4'd4, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 code above 3
        '{20'h8FFFF, 3'b001, 4'd0, 4'd2, 1'b0, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 format above 1
        '{20'h8FFFF, 3'b011, 4'd2, 4'd0, 1'b0, 4'd5,  16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8}  // R8 multi on mixed code
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [19:0] f, input logic [7:0] t,
                            input logic [3:0] d, input logic [3:0] m);
        @(negedge clk);
        cfg_filter = f; cfg_type = t; cfg_dir = d; cfg_fmt = m; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic set_hdr(input logic v, input logic ob, input logic [3:0] p,
                           input logic [15:0] r, input logic [1:0] k,
                           input logic b, input logic [127:0] d);
        hdr_valid = v; hdr_outbound = ob; hdr_port = p; hdr_rid = r;
        hdr_kind = k; hdr_cpl_b = b; hdr_data = d;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] last;
        repeat (3) @(negedge clk);
        chk("R1 reset cap_valid", {127'b0, cap_valid}, 128'd0);
        chk("R1 reset cfg_error", {127'b0, cfg_error}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no load yet, matching-looking header is dropped
        set_hdr(1'b1, 1'b0, 4'd0, 16'h0000, 2'd0, 1'b0, 128'h1111);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R1 no capture before load", {127'b0, cap_valid}, 128'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [127:0] d;
            v = VECS[i];
            d = {4{32'hA5000000 | 32'(i)}};
            load_cfg(v.filt, {5'b0, v.typ}, v.dir, v.fmt);
            set_hdr(1'b1, v.ob, v.port, v.rid, v.kind, v.cplb, d);
            @(negedge clk);
            hdr_valid = 1'b0;
            chk($sformatf("R%0d vec%0d cap_valid", v.req, i), {127'b0, cap_valid}, {127'b0, v.exp_cap});
            chk($sformatf("R%0d vec%0d cfg_error", v.req, i), {127'b0, cfg_error}, {127'b0, v.exp_err});
            if (v.exp_cap)
                chk($sformatf("R%0d vec%0d cap_data", v.req, i), cap_data, d);
        end

        // R2 / R9: legal load, then three back-to-back headers
        load_cfg(20'h8FFFF, 8'h07, 4'd0, 4'd0);
        chk("R2 cfg_error after legal load", {127'b0, cfg_error}, 128'd0);
        set_hdr(1'b1, 1'b0, 4'd1, 16'h0, 2'd0, 1'b0, 128'hB1);
        @(negedge clk);
        chk("R9 b2b first valid", {127'b0, cap_valid}, 128'd1);
        chk("R9 b2b first data", cap_data, 128'hB1);
        set_hdr(1'b1, 1'b0, 4'd2, 16'h0, 2'd1, 1'b0, 128'hB2);
        @(negedge clk);
        chk("R9 b2b second data", cap_data, 128'hB2);
        set_hdr(1'b1, 1'b0, 4'd3, 16'h0, 2'd2, 1'b1, 128'hB3);
        @(negedge clk);
        chk("R9 b2b third data", cap_data, 128'hB3);
        last = 128'hB3;
        // R9: rejected outbound header leaves data untouched
        set_hdr(1'b1, 1'b1, 4'd3, 16'h0, 2'd0, 1'b0, 128'hDEAD);
        @(negedge clk);
        chk("R9 rejected valid", {127'b0, cap_valid}, 128'd0);
        chk("R9 rejected hold", cap_data, last);
        // R10: strobe low, otherwise matching
        set_hdr(1'b0, 1'b0, 4'd3, 16'h0, 2'd0, 1'b0, 128'hBEEF);
        @(negedge clk);
        chk("R10 idle valid", {127'b0, cap_valid}, 128'd0);
        chk("R10 idle hold", cap_data, last);

        // R8: sticky error over several headers, then recovery
        load_cfg(20'h8FFFF, 8'h03, 4'd1, 4'd0);
        for (int j = 0; j < 3; j++) begin
            set_hdr(1'b1, 1'b1, 4'd0, 16'h0, 2'd0, 1'b0, 128'hC0 + 128'(j));
            @(negedge clk);
            chk("R8 sticky no capture", {127'b0, cap_valid}, 128'd0);
            chk("R8 sticky flag", {127'b0, cfg_error}, 128'd1);
        end
        hdr_valid = 1'b0;
        load_cfg(20'h8FFFF, 8'h01, 4'd1, 4'd0);
        chk("R2 error cleared by legal load", {127'b0, cfg_error}, 128'd0);
        set_hdr(1'b1, 1'b1, 4'd0, 16'h0, 2'd0, 1'b0, 128'hCAFE);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R2 capture after recovery", {127'b0, cap_valid}, 128'd1);
        chk("R2 data after recovery", cap_data, 128'hCAFE);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule